// File: doc/BRIEF.md
# Eight-bit timer with two compare channels

This block is an 8-bit up-counter. It advances on a count tick chosen by a 3-bit clock-select field. The tick can be off, every system clock, a prescaled system clock, or one edge polarity of an external input pin. The external pin goes through a two-flop synchronizer, and every edge of the selected polarity gives one tick. This holds whatever drives the pin, so software that owns the pin can step the counter itself.

Two compare registers are tested against the counter on each tick. A match sets that channel's flag. A tick taken at 255 wraps the counter to 0 and sets the overflow flag. A bus write to the counter loads it at once and suppresses compare matches on the tick that follows. Each flag has a mask bit, and a global enable gates all three interrupt requests. A flag clears when software writes a one to it or when its interrupt is acknowledged.

All registers sit on a simple register bus. Writes are synchronous. The read port is combinational.

Top module: `tmr8_unit`

## Requirements
- R1: After reset, every register reads zero: control (address 0), counter (1), compare A (2), compare B (3), mask (4) and flags (5). All interrupt requests are low.
- R2: Clock-select code 0 (control bits 2..0) holds the counter. Code 1 advances it by one on every system clock.
- R3: Codes 2, 3, 4 and 5 advance the counter once every 8, 64, 256 and 1024 system clocks.
- R4: Code 6 advances the counter by exactly one for each falling edge of `extPin`. Rising edges have no effect. The increment is visible within four clocks of the edge.
- R5: Code 7 advances the counter by exactly one for each rising edge of `extPin`. Falling edges have no effect.
- R6: A bus write to address 1 loads the counter. A read of address 1 returns the current count.
- R7: On a tick, if the count before the increment equals compare A, flag bit 1 is set. If it equals compare B, flag bit 2 is set.
- R8: A counter write suppresses compare matches on the first tick after it, and only on that tick.
- R9: A tick taken at count 255 wraps the counter to 0 and sets flag bit 0 (overflow).
- R10: The mask register keeps bits 2 (compare B), 1 (compare A) and 0 (overflow). Bits 7..3 of the mask and control registers always read zero.
- R11: `intReq[i]` is high exactly when flag bit i, mask bit i and `globalIntEn` are all set.
- R12: Writing a one to a bit at address 5 clears that flag, and so does pulsing `intAck[i]`. A flag set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 3 | Register address |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for busAddr (combinational) |
| extPin | input | 1 | External count input |
| globalIntEn | input | 1 | Global interrupt enable |
| intAck | input | 3 | Per-source acknowledge; clears the flag |
| intReq | output | 3 | Interrupt requests: bit 2 compare B, bit 1 compare A, bit 0 overflow |

## Verification
Most internal faults show at the counter read port within one tick. A wrong prescaler tap or a wrong edge polarity changes the measured spacing between count changes, or the number of steps taken per pin pulse. A stuck suppression bit shows as a missing match flag on a tick one step later than expected. A suppression bit that never sets shows as a flag on the tick right after a counter write. Faults in the flags or the mask appear on `intReq` in the same cycle as the bad state.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam int NUM_SRC = 3;
  localparam int SEL_W = 3;

  localparam logic [ADDR_W-1:0] ADR_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_COUNT = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_CMPA  = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_CMPB  = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_MASK  = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_FLAGS = 3'd5;

  typedef struct packed {
    logic              tick;
    logic              cntWr;
    logic              cmpAWr;
    logic              cmpBWr;
    logic              flagClrWr;
    logic [DATA_W-1:0] wrData;
  } tmrStrobe_t;
endpackage

// File: rtl/tmr8_ctrl.sv
module tmr8_ctrl
  import tmr8_pkg::*;
#(
  parameter int PRE_W = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWrEn,
  input  logic [DATA_W-1:0]  busWrData,
  input  logic               extPin,
  output tmrStrobe_t         strobe,
  output logic [SEL_W-1:0]   clkSel,
  output logic [NUM_SRC-1:0] maskBits
);
  localparam int NUM_TAPS = 4;
  localparam int TAP_SH [NUM_TAPS] = '{3, 6, 8, PRE_W};

  logic [PRE_W-1:0] preCnt;
  logic [2:0]       pinSync;
  logic [NUM_TAPS-1:0] tapHit;
  logic pinRise, pinFall, tickSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt   <= '0;
      pinSync  <= '0;
      clkSel   <= '0;
      maskBits <= '0;
    end else begin
      preCnt  <= preCnt + 1'b1;
      pinSync <= {pinSync[1:0], extPin};
      if (busWrEn && busAddr == ADR_CTRL) clkSel <= busWrData[SEL_W-1:0];
      if (busWrEn && busAddr == ADR_MASK) maskBits <= busWrData[NUM_SRC-1:0];
    end
  end

  for (genvar g = 0; g < NUM_TAPS; g++) begin : gTap
    assign tapHit[g] = &preCnt[TAP_SH[g]-1:0];
  end

  assign pinRise = pinSync[1] & ~pinSync[2];
  assign pinFall = ~pinSync[1] & pinSync[2];

  always_comb begin
    case (clkSel)
      3'd1:    tickSel = 1'b1;
      3'd2:    tickSel = tapHit[0];
      3'd3:    tickSel = tapHit[1];
      3'd4:    tickSel = tapHit[2];
      3'd5:    tickSel = tapHit[3];
      3'd6:    tickSel = pinFall;
      3'd7:    tickSel = pinRise;
      default: tickSel = 1'b0;
    endcase
  end

  always_comb begin
    strobe.tick      = tickSel;
    strobe.cntWr     = busWrEn && busAddr == ADR_COUNT;
    strobe.cmpAWr    = busWrEn && busAddr == ADR_CMPA;
    strobe.cmpBWr    = busWrEn && busAddr == ADR_CMPB;
    strobe.flagClrWr = busWrEn && busAddr == ADR_FLAGS;
    strobe.wrData    = busWrData;
  end
endmodule

// File: rtl/tmr8_datapath.sv
module tmr8_datapath
  import tmr8_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  tmrStrobe_t         strobe,
  input  logic [NUM_SRC-1:0] maskBits,
  input  logic               globalIntEn,
  input  logic [NUM_SRC-1:0] intAck,
  output logic [DATA_W-1:0]  count,
  output logic [DATA_W-1:0]  cmpA,
  output logic [DATA_W-1:0]  cmpB,
  output logic [NUM_SRC-1:0] flags,
  output logic [NUM_SRC-1:0] intReq
);
  logic blockCmp, stepOk, matchOk;
  logic [NUM_SRC-1:0] setMask, clrMask;

  assign stepOk  = strobe.tick && !strobe.cntWr;
  assign matchOk = stepOk && !blockCmp;
  assign setMask = {matchOk && count == cmpB,
                    matchOk && count == cmpA,
                    stepOk && count == {DATA_W{1'b1}}};
  assign clrMask = intAck |
                   (strobe.flagClrWr ? strobe.wrData[NUM_SRC-1:0] : '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count    <= '0;
      cmpA     <= '0;
      cmpB     <= '0;
      flags    <= '0;
      blockCmp <= 1'b0;
    end else begin
      if (strobe.cmpAWr) cmpA <= strobe.wrData;
      if (strobe.cmpBWr) cmpB <= strobe.wrData;
      if (strobe.cntWr) begin
        count    <= strobe.wrData;
        blockCmp <= 1'b1;
      end else if (strobe.tick) begin
        count    <= count + 1'b1;
        blockCmp <= 1'b0;
      end
      flags <= (flags & ~clrMask) | setMask;
    end
  end

  assign intReq = flags & maskBits & {NUM_SRC{globalIntEn}};
endmodule

// File: rtl/tmr8_unit.sv
module tmr8_unit
  import tmr8_pkg::*;
#(
  parameter int PRE_W = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWrEn,
  input  logic [DATA_W-1:0]  busWrData,
  output logic [DATA_W-1:0]  busRdData,
  input  logic               extPin,
  input  logic               globalIntEn,
  input  logic [NUM_SRC-1:0] intAck,
  output logic [NUM_SRC-1:0] intReq
);
  tmrStrobe_t         strobe;
  logic [SEL_W-1:0]   clkSel;
  logic [NUM_SRC-1:0] maskBits, flags;
  logic [DATA_W-1:0]  count, cmpA, cmpB;
  logic               tickSeen;

  assign tickSeen = strobe.tick;

  tmr8_ctrl #(.PRE_W(PRE_W)) uCtrl (
    .clk, .rstN, .busAddr, .busWrEn, .busWrData, .extPin,
    .strobe, .clkSel, .maskBits
  );

  tmr8_datapath uData (
    .clk, .rstN, .strobe, .maskBits, .globalIntEn, .intAck,
    .count, .cmpA, .cmpB, .flags, .intReq
  );

  always_comb begin
    case (busAddr)
      ADR_CTRL:  busRdData = DATA_W'(clkSel);
      ADR_COUNT: busRdData = count;
      ADR_CMPA:  busRdData = cmpA;
      ADR_CMPB:  busRdData = cmpB;
      ADR_MASK:  busRdData = DATA_W'(maskBits);
      ADR_FLAGS: busRdData = DATA_W'(flags);
      default:   busRdData = '0;
    endcase
  end
endmodule

// File: rtl/tmr8_checker.sv
module tmr8_checker (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] busAddr,
  input logic       busWrEn,
  input logic [7:0] busRdData,
  input logic       globalIntEn,
  input logic [2:0] clkSel,
  input logic [7:0] count,
  input logic [2:0] flags,
  input logic       tick,
  input logic [2:0] intReq
);
  logic cntWr, wrLast;
  assign cntWr = busWrEn && busAddr == 3'd1;

  always_ff @(posedge clk) begin
    if (!rstN) wrLast <= 1'b0;
    else       wrLast <= cntWr;
  end

  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (clkSel == 3'd0 && !cntWr) |=> $stable(count)); // R2

  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rstN)
    !cntWr |=> (count == $past(count) || count == 8'($past(count) + 8'd1))); // R6

  AST_WRAP_SETS_OVF: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !cntWr && count == 8'hFF) |=> (count == 8'd0 && flags[0])); // R9

  AST_WRITE_BLOCKS_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (wrLast && tick && !cntWr && !flags[1]) |=> !flags[1]); // R8

  AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rstN)
    !globalIntEn |-> intReq == 3'b000); // R11

  AST_RSVD_MASK_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    busAddr == 3'd4 |-> busRdData[7:3] == 5'd0); // R10
endmodule

bind tmr8_unit tmr8_checker uChk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
  .busRdData(busRdData), .globalIntEn(globalIntEn), .clkSel(clkSel),
  .count(count), .flags(flags), .tick(tickSeen), .intReq(intReq)
);

// File: tb/tmr8_unit_test.sv
`timescale 1ns/1ps
module tmr8_unit_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] busAddr = '0;
  logic       busWrEn = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic       extPin = 1'b0;
  logic       globalIntEn = 1'b0;
  logic [2:0] intAck = '0;
  logic [2:0] intReq;
  int nChecks = 0;
  int nFails = 0;

  always #2.5 clk = ~clk;

  tmr8_unit uut (.*);

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    @(negedge clk);
    busAddr = a;
    #1 v = int'(busRdData);
  endtask

  task automatic pinStep(input logic lvl);
    @(negedge clk);
    extPin = lvl;
    repeat (4) @(negedge clk);
  endtask

  task automatic testReset();
    int v;
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      check("R1 reg", v, 0);
    end
    check("R1 intReq", int'(intReq), 0);
  endtask

  task automatic testStopAndFull();
    int c0, c1;
    wr(3'd0, 8'd0);
    wr(3'd1, 8'd5);
    repeat (20) @(negedge clk);
    rd(3'd1, c0);
    check("R2 stopped", c0, 5);
    check("R6 readback", c0, 5);
    wr(3'd0, 8'd1);
    rd(3'd1, c0);
    repeat (9) @(negedge clk);
    rd(3'd1, c1);
    check("R2 every clock", (c1 - c0) & 255, 10);
    wr(3'd0, 8'd0);
  endtask

  task automatic measure(input logic [7:0] code, input int expPeriod);
    int prev, cur, n;
    wr(3'd0, code);
    rd(3'd1, prev);
    n = 0;
    do begin rd(3'd1, cur); n++; end while (cur == prev && n < 2100);
    prev = cur; n = 0;
    do begin rd(3'd1, cur); n++; end while (cur == prev && n < 2100);
    check("R3 period", n, expPeriod);
  endtask

  task automatic testPrescale();
    measure(8'd2, 8);
    measure(8'd3, 64);
    measure(8'd4, 256);
    measure(8'd5, 1024);
    wr(3'd0, 8'd0);
  endtask

  task automatic testExt(input logic [7:0] code, input string req);
    int v;
    logic act;
    act = (code == 8'd7);
    pinStep(~act);
    wr(3'd1, 8'd0);
    wr(3'd0, code);
    pinStep(act);
    rd(3'd1, v);
    check(req, v, 1);
    pinStep(~act);
    rd(3'd1, v);
    check(req, v, 1);
    for (int i = 0; i < 3; i++) begin
      pinStep(act);
      pinStep(~act);
    end
    rd(3'd1, v);
    check(req, v, 4);
  endtask

  task automatic pulse();
    pinStep(1'b1);
    pinStep(1'b0);
  endtask

  task automatic testCompare();
    int v;
    wr(3'd0, 8'd7);
    wr(3'd2, 8'd10);
    wr(3'd3, 8'd12);
    wr(3'd1, 8'd9);
    wr(3'd5, 8'd7);
    pulse();
    rd(3'd5, v);
    check("R7 no early match", v, 0);
    pulse();
    rd(3'd5, v);
    check("R7 match A", v, 2);
    pulse(); pulse();
    rd(3'd5, v);
    check("R7 match B", v, 6);
    wr(3'd5, 8'd7);
    rd(3'd5, v);
    check("R12 w1c", v, 0);
  endtask

  task automatic testBlock();
    int v;
    wr(3'd3, 8'd11);
    wr(3'd1, 8'd10);
    pulse();
    rd(3'd5, v);
    check("R8 blocked", v, 0);
    rd(3'd1, v);
    check("R8 count", v, 11);
    pulse();
    rd(3'd5, v);
    check("R8 next tick matches", v, 4);
    wr(3'd5, 8'd7);
  endtask

  task automatic testOverflow();
    int v;
    wr(3'd2, 8'd100);
    wr(3'd3, 8'd100);
    wr(3'd1, 8'd254);
    pulse();
    rd(3'd5, v);
    check("R9 no ovf at 254", v, 0);
    pulse();
    rd(3'd1, v);
    check("R9 wrap", v, 0);
    rd(3'd5, v);
    check("R9 ovf flag", v, 1);
  endtask

  task automatic testMaskIrq();
    int v;
    wr(3'd4, 8'hFF);
    rd(3'd4, v);
    check("R10 reserved", v, 7);
    wr(3'd0, 8'hFF);
    rd(3'd0, v);
    check("R10 ctrl reserved", v, 7);
    wr(3'd0, 8'd0);
    globalIntEn = 1'b0;
    #1 check("R11 global off", int'(intReq), 0);
    @(negedge clk) globalIntEn = 1'b1;
    #1 check("R11 ovf req", int'(intReq), 1);
    wr(3'd4, 8'd6);
    #1 check("R11 masked", int'(intReq), 0);
    wr(3'd4, 8'd7);
    @(negedge clk) intAck = 3'b001;
    @(negedge clk) intAck = 3'b000;
    rd(3'd5, v);
    check("R12 ack clears", v, 0);
    check("R11 req drops", int'(intReq), 0);
  endtask

  initial begin
    #(5.0 * 150000);
    nFails++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testStopAndFull();
    testPrescale();
    testExt(8'd6, "R4 falling");
    testExt(8'd7, "R5 rising");
    testCompare();
    testBlock();
    testOverflow();
    testMaskIrq();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule